// File: doc/BRIEF.md
# Tap-Select Pulse-Width Modulator with Temporal Dither

This block produces the switch-control pulse of a buck converter from a 10-bit duty word. A phase counter that runs at 32 times the switching rate stands in for the taps of a ring oscillator. The upper five bits of the duty word select the tap at which the pulse ends. The lower five bits are spread in time: a small accumulator lengthens the pulse by one tap in some periods. Averaged over 32 periods, this gives the full 10-bit resolution.

The duty word is captured once per switching period, at the boundary between two periods. The captured value then holds for the whole period. Three override inputs take effect at once and do not wait for the next period. Two of them force the output low and one forces it high for the entire period. The two that force the output low win over the one that forces it high. A one-cycle strobe marks the start of every period, so a control loop can update its command in step with the modulator.

Top module: `dpwm_dither_top`

## Requirements
- R1: A switching period lasts 32 clock cycles. `period_start` is high for exactly one cycle per period, in the first cycle of the period.
- R2: The coarse code is `duty_cmd[9:5]`. When no override is active and no dither step applies, `pwm_out` is high for the first `coarse` cycles of the period and low for the remaining cycles.
- R3: `duty_cmd`, `dither_en` and the dither step are captured only at the boundary between periods. A change to `duty_cmd` in the middle of a period does not alter that period's pulse, but it does set the width of the next period.
- R4: A coarse code of 0 with no dither step keeps `pwm_out` low for the whole period.
- R5: The fine code is `k = duty_cmd[4:0]`. With `dither_en` high, a 5-bit accumulator starting from 0 adds `k` once per period. Each period in which this addition overflows is one cycle longer. Over any 32 periods at constant `k`, exactly `k` periods are lengthened, and they are spread as evenly as the accumulator allows.
- R6: With `dither_en` low, the fine code has no effect on the width of any period.
- R7: With a coarse code of 31, a dither step gives a full period of 32 high cycles, and the width never goes beyond full-on.
- R8: `force_on` holds `pwm_out` high for all 32 cycles of a period, whatever the duty word is.
- R9: `force_off` or `pwm_off` holds `pwm_out` low, and either of them takes priority over `force_on`.
- R10: While `rst` is high and after it is released, the phase is 0, the dither accumulator is 0 and the captured width is 0. The first period after reset is therefore low whatever the duty word is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tap clock at 32 times the switching rate |
| rst | input | 1 | Synchronous active-high reset |
| duty_cmd | input | 10 | Coarse tap code in bits 9:5, fine dither code in bits 4:0 |
| dither_en | input | 1 | Enables the temporal dither of the fine code |
| force_on | input | 1 | Holds the output high |
| force_off | input | 1 | Holds the output low; wins over force_on |
| pwm_off | input | 1 | Modulator disable; holds the output low |
| pwm_out | output | 1 | Switch-control pulse |
| period_start | output | 1 | One-cycle strobe in the first cycle of each period |

## Verification
The bench checks the boundary codes. A coarse code of 0 must give no high cycle at all, and a design that is off by one in its compare would show a one-cycle sliver. A coarse code of 31 combined with a fine code of 31 must give full periods and never wrap to a narrow pulse. A design that wraps would show a sudden near-zero width in the periods that get the dither step. The bench also changes the duty word in the middle of a period and checks that nothing changes until the boundary. It checks that over 32 periods the number of lengthened periods matches the fine code exactly, since a wrong accumulator gives the wrong average duty.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
    localparam int unsigned COARSE_BITS = 5;
    localparam int unsigned FINE_BITS   = 5;
    localparam int unsigned DUTY_BITS   = COARSE_BITS + FINE_BITS;
    localparam int unsigned WIDTH_BITS  = COARSE_BITS + 1;

    typedef struct packed {
        logic [COARSE_BITS-1:0] coarse;
        logic [FINE_BITS-1:0]   fine;
    } duty_word_t;

    typedef enum logic [1:0] {
        DRIVE_PULSE = 2'd0,
        DRIVE_HIGH  = 2'd1,
        DRIVE_LOW   = 2'd2
    } drive_mode_t;

    // Coarse code plus a one-tap step; at most 2**COARSE_BITS (full-on).
    function automatic logic [WIDTH_BITS-1:0] step_width(
        input logic [COARSE_BITS-1:0] coarse,
        input logic                   bump
    );
        return {1'b0, coarse} + {{(WIDTH_BITS-1){1'b0}}, bump};
    endfunction

    function automatic drive_mode_t pick_mode(
        input logic on_req,
        input logic off_req
    );
        if (off_req)     return DRIVE_LOW;
        else if (on_req) return DRIVE_HIGH;
        else             return DRIVE_PULSE;
    endfunction
endpackage

// File: rtl/dpwm_phase_gen.sv
module dpwm_phase_gen #(
    parameter int unsigned PH_BITS = dpwm_pkg::COARSE_BITS
) (
    input  logic               clk,
    input  logic               rst,
    output logic [PH_BITS-1:0] phase,
    output logic               first_slot,
    output logic               last_slot
);
    localparam logic [PH_BITS-1:0] PH_LAST = {PH_BITS{1'b1}};

    logic [PH_BITS-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= '0;
        else     phase_q <= phase_q + 1'b1;
    end

    assign phase      = phase_q;
    assign first_slot = (phase_q == '0);
    assign last_slot  = (phase_q == PH_LAST);

    // R1
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        first_slot |=> !first_slot);
    // R1
    phase_advance_chk: assert property (@(posedge clk) disable iff (rst)
        last_slot |=> first_slot);
endmodule

// File: rtl/dpwm_dither_acc.sv
module dpwm_dither_acc #(
    parameter int unsigned F_BITS = dpwm_pkg::FINE_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              enable,
    input  logic [F_BITS-1:0] fine,
    output logic              bump
);
    generate
        if (F_BITS > 0) begin : g_acc
            logic [F_BITS-1:0] acc_q;
            logic [F_BITS:0]   sum;

            always_comb begin
                sum = {1'b0, acc_q} + {1'b0, (enable ? fine : {F_BITS{1'b0}})};
            end

            always_ff @(posedge clk) begin
                if (rst)       acc_q <= '0;
                else if (load) acc_q <= sum[F_BITS-1:0];
            end

            assign bump = sum[F_BITS];

            // R6
            no_bump_when_off_chk: assert property (@(posedge clk) disable iff (rst)
                !enable |-> !bump);
            // R5
            acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
                !load |=> $stable(acc_q));
        end else begin : g_none
            assign bump = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/dpwm_pulse_out.sv
module dpwm_pulse_out
    import dpwm_pkg::*;
#(
    parameter int unsigned C_BITS = COARSE_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [C_BITS-1:0] coarse,
    input  logic              bump,
    input  logic [C_BITS-1:0] phase,
    input  logic              on_req,
    input  logic              off_req,
    output logic              pulse
);
    localparam int unsigned W_BITS = C_BITS + 1;
    localparam logic [W_BITS-1:0] FULL = W_BITS'(1) << C_BITS;

    logic [W_BITS-1:0] width_q;
    logic              compare_hit;
    drive_mode_t       mode;

    always_ff @(posedge clk) begin
        if (rst)       width_q <= '0;
        else if (load) width_q <= step_width(coarse, bump);
    end

    always_comb begin
        compare_hit = ({1'b0, phase} < width_q);
        mode        = pick_mode(on_req, off_req);
        unique case (mode)
            DRIVE_LOW:  pulse = 1'b0;
            DRIVE_HIGH: pulse = 1'b1;
            default:    pulse = compare_hit;
        endcase
    end

    // R7
    width_sat_chk: assert property (@(posedge clk) disable iff (rst)
        width_q <= FULL);
    // R3
    width_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(width_q));
    // R4
    zero_width_chk: assert property (@(posedge clk) disable iff (rst)
        (width_q == '0 && !on_req) |-> !pulse);
    // R9
    off_priority_chk: assert property (@(posedge clk) disable iff (rst)
        off_req |-> !pulse);
endmodule

// File: rtl/dpwm_dither_top.sv
module dpwm_dither_top
    import dpwm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DUTY_BITS-1:0] duty_cmd,
    input  logic                 dither_en,
    input  logic                 force_on,
    input  logic                 force_off,
    input  logic                 pwm_off,
    output logic                 pwm_out,
    output logic                 period_start
);
    duty_word_t             duty;
    logic [COARSE_BITS-1:0] phase;
    logic                   first_slot;
    logic                   last_slot;
    logic                   bump;

    assign duty = duty_word_t'(duty_cmd);

    dpwm_phase_gen #(.PH_BITS(COARSE_BITS)) u_phase (
        .clk        (clk),
        .rst        (rst),
        .phase      (phase),
        .first_slot (first_slot),
        .last_slot  (last_slot)
    );

    dpwm_dither_acc #(.F_BITS(FINE_BITS)) u_dither (
        .clk    (clk),
        .rst    (rst),
        .load   (last_slot),
        .enable (dither_en),
        .fine   (duty.fine),
        .bump   (bump)
    );

    dpwm_pulse_out #(.C_BITS(COARSE_BITS)) u_pulse (
        .clk     (clk),
        .rst     (rst),
        .load    (last_slot),
        .coarse  (duty.coarse),
        .bump    (bump),
        .phase   (phase),
        .on_req  (force_on),
        .off_req (force_off | pwm_off),
        .pulse   (pwm_out)
    );

    assign period_start = first_slot;

    // R8
    force_high_chk: assert property (@(posedge clk) disable iff (rst)
        (force_on && !force_off && !pwm_off) |-> pwm_out);
    // R2
    pulse_starts_chk: assert property (@(posedge clk) disable iff (rst)
        (period_start && !pwm_out && !force_on) |=> (!pwm_out || force_on));
endmodule

// File: tb/sim_dpwm_dither_top.sv
module sim_dpwm_dither_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] duty_cmd = '0;
    logic       dither_en = 1'b0;
    logic       force_on = 1'b0;
    logic       force_off = 1'b0;
    logic       pwm_off = 1'b0;
    logic       pwm_out;
    logic       period_start;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [4:0] macc = '0;

    always #4 clk = ~clk;

    dpwm_dither_top u0 (
        .clk(clk), .rst(rst), .duty_cmd(duty_cmd), .dither_en(dither_en),
        .force_on(force_on), .force_off(force_off), .pwm_off(pwm_off),
        .pwm_out(pwm_out), .period_start(period_start)
    );

    // row: duty[19:10] en[9] fon[8] foff[7] poff[6] expected_width[5:0]
    localparam logic [19:0] TBL [10] = '{
        {10'h000, 1'b0, 1'b0, 1'b0, 1'b0, 6'd0},
        {10'h200, 1'b0, 1'b0, 1'b0, 1'b0, 6'd16},
        {10'h03F, 1'b0, 1'b0, 1'b0, 1'b0, 6'd1},
        {10'h3E0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd31},
        {10'h0A0, 1'b0, 1'b1, 1'b0, 1'b0, 6'd32},
        {10'h0A0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd0},
        {10'h280, 1'b0, 1'b1, 1'b1, 1'b0, 6'd0},
        {10'h280, 1'b0, 1'b0, 1'b0, 1'b1, 6'd0},
        {10'h280, 1'b0, 1'b1, 1'b0, 1'b1, 6'd0},
        {10'h0E0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd7}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Model of one period boundary (R5, R6): width captured for next period.
    function automatic int model_step(input logic [9:0] d, input logic en);
        logic [5:0] s;
        s = {1'b0, macc} + {1'b0, (en ? d[4:0] : 5'd0)};
        macc = s[4:0];
        return int'(d[9:5]) + int'(s[5]);
    endfunction

    function automatic int apply_ovr(input int w);
        if (force_off || pwm_off) return 0;
        if (force_on) return 32;
        return w;
    endfunction

    // Called at a negedge; measures one whole period starting at its strobe.
    task automatic meas(output int cnt, output int shape_ok, output int strobes,
                        input bit mid, input logic [9:0] mid_duty);
        cnt = 0; shape_ok = 1; strobes = 0;
        while (!period_start) @(negedge clk);
        for (int i = 0; i < 32; i++) begin
            if (i > 0) @(negedge clk);
            cnt += int'(pwm_out);
            strobes += int'(period_start);
            if (i > 0 && pwm_out && (cnt != i + 1)) shape_ok = 0;
            if (mid && i == 10) duty_cmd = mid_duty;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int c, sh, st, e, sum;
        duty_cmd = 10'h280;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 strobe in reset", int'(period_start), 1);
        check("R10 output in reset", int'(pwm_out), 0);
        rst = 1'b0;
        macc = '0;
        e = model_step(duty_cmd, dither_en);
        meas(c, sh, st, 1'b0, '0);
        check("R10 first period width", c, 0);
        check("R1 one strobe per period", st, 1);
        meas(c, sh, st, 1'b0, '0);
        check("R2 width after reset", c, e);

        // Vector table walk: R2 R4 R6 R7 R8 R9
        for (int r = 0; r < 10; r++) begin
            duty_cmd  = TBL[r][19:10];
            dither_en = TBL[r][9];
            force_on  = TBL[r][8];
            force_off = TBL[r][7];
            pwm_off   = TBL[r][6];
            e = apply_ovr(model_step(duty_cmd, dither_en));
            meas(c, sh, st, 1'b0, '0);
            check("R2/R4/R6/R8/R9 table width", c, int'(TBL[r][5:0]));
            check("R2/R4/R6/R8/R9 table model", c, e);
            check("R2 contiguous pulse", sh, 1);
            check("R1 strobe count", st, 1);
        end
        force_on = 0; force_off = 0; pwm_off = 0;

        // R5: k=1 coarse 10, one lengthened period in 32
        duty_cmd = 10'h141; dither_en = 1'b1; sum = 0;
        for (int p = 0; p < 32; p++) begin
            e = model_step(duty_cmd, dither_en);
            meas(c, sh, st, 1'b0, '0);
            sum += c;
            if (p == 31) check("R5 k=1 last period lengthened", c, 11);
            else if (c != e) check("R5 k=1 period width", c, e);
        end
        check("R5 k=1 sum over 32", sum, 321);

        // R5: k=16 coarse 3 alternates 3,4
        duty_cmd = 10'h070;
        for (int p = 0; p < 4; p++) begin
            e = model_step(duty_cmd, dither_en);
            meas(c, sh, st, 1'b0, '0);
            check("R5 k=16 alternation", c, (p % 2 == 0) ? 3 : 4);
        end

        // R7: coarse 31 fine 31 saturates at full-on
        duty_cmd = 10'h3FF; sum = 0;
        for (int p = 0; p < 32; p++) begin
            e = model_step(duty_cmd, dither_en);
            meas(c, sh, st, 1'b0, '0);
            sum += c;
            if (c != e || c > 32) check("R7 saturated width", c, e);
        end
        check("R7 sum over 32", sum, 1023);

        // R6: dither disabled ignores fine bits
        duty_cmd = 10'h13F; dither_en = 1'b0;
        for (int p = 0; p < 3; p++) begin
            e = model_step(duty_cmd, dither_en);
            meas(c, sh, st, 1'b0, '0);
            check("R6 fine ignored", c, 9);
        end

        // R3: mid-period change has no effect until boundary
        duty_cmd = 10'h180;
        e = model_step(duty_cmd, dither_en);
        meas(c, sh, st, 1'b0, '0);
        check("R3 setup width", c, 12);
        e = model_step(10'h040, dither_en);
        meas(c, sh, st, 1'b1, 10'h040);
        check("R3 mid change ignored", c, 12);
        meas(c, sh, st, 1'b0, '0);
        check("R3 new width next period", c, 2);

        // R10: reset mid-run
        duty_cmd = 10'h280; dither_en = 1'b1;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        macc = '0;
        e = model_step(duty_cmd, dither_en);
        meas(c, sh, st, 1'b0, '0);
        check("R10 width cleared by reset", c, 0);
        meas(c, sh, st, 1'b0, '0);
        check("R10 width after re-reset", c, e);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule